// File: doc/BRIEF.md
# Instruction Immediate Generator

This combinational block takes one 32-bit base-integer instruction word and returns the immediate operand that the word encodes. It looks at the 7-bit major opcode to decide which of five immediate layouts applies (register-immediate, store, conditional branch, upper, jump). It then gathers the scattered instruction bits into a contiguous value and sign-extends that value to the datapath width. The sign always comes from instruction bit 31, so sign extension does not have to wait for the layout decision.

It also produces two outputs for the immediate shift instructions: the 5-bit shift count, and a flag that selects the arithmetic right shift. A third flag marks words whose opcode carries no immediate. For such words the immediate output is forced to zero. A decode stage uses the block next to the register-file read ports. Register access, the remaining decode and execution are handled elsewhere.

Top module: `imm_operand_gen`

## Requirements
- R1: For opcodes 0010011, 0000011 and 1100111 (bits 6:0), the immediate is instruction bits 31:20 placed in immediate bits 11:0 and sign-extended.
- R2: For opcode 0100011, immediate bits 4:0 come from instruction bits 11:7, and immediate bits 10:5 come from instruction bits 30:25. The value is sign-extended from instruction bit 31.
- R3: For opcode 1100011, immediate bit 0 is zero and bits 4:1 come from instruction bits 11:8. Bits 10:5 come from instruction bits 30:25 and bit 11 comes from instruction bit 7. The value is sign-extended from instruction bit 31.
- R4: For opcodes 0110111 and 0010111, immediate bits 31:12 equal instruction bits 31:12 and immediate bits 11:0 are zero.
- R5: For opcode 1101111, immediate bit 0 is zero and bits 10:1 come from instruction bits 30:21. Bit 11 comes from instruction bit 20 and bits 19:12 come from instruction bits 19:12. The value is sign-extended from instruction bit 31.
- R6: For every opcode that carries an immediate, the most significant immediate bit equals instruction bit 31.
- R7: For any opcode other than the eight listed in R1 to R5, including the register-register opcode 0110011, the immediate is zero and no_imm_o is 1. For the eight listed opcodes, no_imm_o is 0.
- R8: shamt_o equals instruction bits 24:20 when the opcode is 0010011 and bits 14:12 are 001 or 101. Otherwise shamt_o is zero.
- R9: shift_arith_o equals instruction bit 30 when the opcode is 0010011 and bits 14:12 are 101. Otherwise shift_arith_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| imm_o | output | XLEN | Reassembled, sign-extended immediate |
| no_imm_o | output | 1 | Opcode carries no immediate |
| shamt_o | output | 5 | Shift count for immediate shifts |
| shift_arith_o | output | 1 | Immediate right shift is arithmetic |

## Verification
The cases hardest to reach are the lone bits that the branch and jump layouts move far from their immediate position. Instruction bit 7 goes to immediate bit 11, and instruction bit 20 goes to jump bit 11. Uniformly random words rarely isolate one of these bits with the rest of the word quiet. Directed words therefore set exactly one such bit under each opcode, with the sign bit both clear and set. Random words are then drawn from the valid-opcode list, plus the register-register opcode and arbitrary opcodes. They are compared against a model that rebuilds each immediate one bit position at a time.

// File: rtl/imm_gen_pkg.sv
package imm_gen_pkg;

  localparam int ILEN      = 32;
  localparam int OPC_W     = 7;
  localparam int SHAMT_W   = 5;
  localparam int FUNCT3_W  = 3;

  localparam logic [OPC_W-1:0] OPC_OP_IMM = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;

  localparam logic [FUNCT3_W-1:0] F3_SHL = 3'b001;
  localparam logic [FUNCT3_W-1:0] F3_SHR = 3'b101;

  typedef enum logic [2:0] {
    FORM_NONE = 3'd0,
    FORM_I    = 3'd1,
    FORM_S    = 3'd2,
    FORM_B    = 3'd3,
    FORM_U    = 3'd4,
    FORM_J    = 3'd5
  } imm_form_t;

  localparam int N_FORMS = 6;

  function automatic logic [ILEN-1:0] imm_i_of(logic [ILEN-1:7] w);
    return {{20{w[31]}}, w[31:20]};
  endfunction

  function automatic logic [ILEN-1:0] imm_s_of(logic [ILEN-1:7] w);
    return {{20{w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic logic [ILEN-1:0] imm_b_of(logic [ILEN-1:7] w);
    return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  function automatic logic [ILEN-1:0] imm_u_of(logic [ILEN-1:7] w);
    return {w[31:12], 12'b0};
  endfunction

  function automatic logic [ILEN-1:0] imm_j_of(logic [ILEN-1:7] w);
    return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

  function automatic logic [ILEN-1:0] build_imm(imm_form_t f, logic [ILEN-1:7] w);
    logic [ILEN-1:0] r;
    case (f)
      FORM_I:  r = imm_i_of(w);
      FORM_S:  r = imm_s_of(w);
      FORM_B:  r = imm_b_of(w);
      FORM_U:  r = imm_u_of(w);
      FORM_J:  r = imm_j_of(w);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/imm_form_classify.sv
module imm_form_classify
  import imm_gen_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output imm_form_t        form_o,
  output logic             none_o
);

  always_comb begin
    none_o = 1'b0;
    case (opcode_i)
      OPC_OP_IMM, OPC_LOAD, OPC_JALR: form_o = FORM_I;
      OPC_STORE:                      form_o = FORM_S;
      OPC_BRANCH:                     form_o = FORM_B;
      OPC_LUI, OPC_AUIPC:             form_o = FORM_U;
      OPC_JAL:                        form_o = FORM_J;
      default: begin
        form_o = FORM_NONE;
        none_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/imm_field_build.sv
module imm_field_build
  import imm_gen_pkg::*;
(
  input  logic [ILEN-1:7]                 fields_i,
  output logic [N_FORMS-1:0][ILEN-1:0]    cand_o
);

  for (genvar gi = 0; gi < N_FORMS; gi++) begin : g_form
    assign cand_o[gi] = build_imm(imm_form_t'(gi), fields_i);
  end

endmodule

// File: rtl/imm_select.sv
module imm_select
  import imm_gen_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [N_FORMS-1:0][ILEN-1:0] cand_i,
  input  imm_form_t                    form_i,
  output logic [XLEN-1:0]              imm_o
);

  localparam int EXT_W = XLEN - ILEN;

  logic [ILEN-1:0] picked;

  always_comb begin
    picked = '0;
    for (int k = 0; k < N_FORMS; k++) begin
      if (form_i == imm_form_t'(k)) picked = picked | cand_i[k];
    end
  end

  if (EXT_W > 0) begin : g_wide
    assign imm_o = {{EXT_W{picked[ILEN-1]}}, picked};
  end else begin : g_native
    assign imm_o = picked;
  end

endmodule

// File: rtl/imm_shift_decode.sv
module imm_shift_decode
  import imm_gen_pkg::*;
(
  input  logic [OPC_W-1:0]    opcode_i,
  input  logic [FUNCT3_W-1:0] funct3_i,
  input  logic                arith_bit_i,
  input  logic [SHAMT_W-1:0]  count_field_i,
  output logic [SHAMT_W-1:0]  shamt_o,
  output logic                arith_o
);

  logic is_op_imm;
  logic is_shl;
  logic is_shr;

  assign is_op_imm = (opcode_i == OPC_OP_IMM);
  assign is_shl    = is_op_imm && (funct3_i == F3_SHL);
  assign is_shr    = is_op_imm && (funct3_i == F3_SHR);

  assign shamt_o = (is_shl || is_shr) ? count_field_i : '0;
  assign arith_o = is_shr && arith_bit_i;

endmodule

// File: rtl/imm_operand_gen.sv
module imm_operand_gen
  import imm_gen_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]      instr_i,
  output logic [XLEN-1:0]  imm_o,
  output logic             no_imm_o,
  output logic [4:0]       shamt_o,
  output logic             shift_arith_o
);

  imm_form_t                   sel_form;
  logic [N_FORMS-1:0][ILEN-1:0] cand;

  imm_form_classify u_classify (
    .opcode_i (instr_i[OPC_W-1:0]),
    .form_o   (sel_form),
    .none_o   (no_imm_o)
  );

  imm_field_build u_build (
    .fields_i (instr_i[ILEN-1:7]),
    .cand_o   (cand)
  );

  imm_select #(.XLEN(XLEN)) u_select (
    .cand_i (cand),
    .form_i (sel_form),
    .imm_o  (imm_o)
  );

  imm_shift_decode u_shift (
    .opcode_i      (instr_i[OPC_W-1:0]),
    .funct3_i      (instr_i[14:12]),
    .arith_bit_i   (instr_i[30]),
    .count_field_i (instr_i[24:20]),
    .shamt_o       (shamt_o),
    .arith_o       (shift_arith_o)
  );

endmodule

// File: rtl/imm_operand_chk.sv
module imm_operand_chk
  import imm_gen_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] imm_o,
  input logic            no_imm_o,
  input logic [4:0]      shamt_o,
  input logic            shift_arith_o,
  input imm_form_t       sel_form
);

  always_comb begin
    if (!$isunknown(instr_i)) begin
      AST_I_LOW_FIELD: assert (sel_form != FORM_I || imm_o[11:0] == instr_i[31:20]) else $error("I field"); // R1
      AST_S_LOW_FIELD: assert (sel_form != FORM_S || imm_o[4:0] == instr_i[11:7]) else $error("S field"); // R2
      AST_BRANCH_EVEN: assert (sel_form != FORM_B || (!imm_o[0] && imm_o[11] == instr_i[7])) else $error("B layout"); // R3
      AST_UPPER_LOW_CLEAR: assert (sel_form != FORM_U || imm_o[11:0] == 12'h000) else $error("U low"); // R4
      AST_JUMP_EVEN: assert (sel_form != FORM_J || (!imm_o[0] && imm_o[11] == instr_i[20])) else $error("J layout"); // R5
      AST_SIGN_FROM_TOP: assert (no_imm_o || imm_o[XLEN-1] == instr_i[31]) else $error("sign"); // R6
      AST_NOIMM_ZERO: assert (!no_imm_o || imm_o == '0) else $error("no-imm value"); // R7
      AST_SHAMT_IDLE: assert (shamt_o == 5'd0 || instr_i[6:0] == OPC_OP_IMM) else $error("shamt"); // R8
      AST_ARITH_ONLY_SRAI: assert (!shift_arith_o || (instr_i[30] && instr_i[14:12] == F3_SHR)) else $error("arith"); // R9
    end
  end

endmodule

bind imm_operand_gen imm_operand_chk #(.XLEN(XLEN)) u_chk (
  .instr_i       (instr_i),
  .imm_o         (imm_o),
  .no_imm_o      (no_imm_o),
  .shamt_o       (shamt_o),
  .shift_arith_o (shift_arith_o),
  .sel_form      (sel_form)
);

// File: tb/test_imm_operand_gen.sv
module test_imm_operand_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr;
  logic [31:0] imm;
  logic        no_imm;
  logic [4:0]  shamt;
  logic        arith;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  imm_operand_gen #(.XLEN(32)) i_imm_operand_gen (
    .instr_i       (instr),
    .imm_o         (imm),
    .no_imm_o      (no_imm),
    .shamt_o       (shamt),
    .shift_arith_o (arith)
  );

  localparam logic [6:0] OPS [10] = '{7'b0010011, 7'b0000011, 7'b1100111, 7'b0100011,
                                      7'b1100011, 7'b0110111, 7'b0010111, 7'b1101111,
                                      7'b0110011, 7'b1110011};

  function automatic int kind_of(logic [6:0] op);
    case (op)
      7'b0010011, 7'b0000011, 7'b1100111: return 1;
      7'b0100011: return 2;
      7'b1100011: return 3;
      7'b0110111, 7'b0010111: return 4;
      7'b1101111: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(logic [6:0] op);
    case (kind_of(op))
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [31:0] ref_imm(logic [31:0] w);
    logic [31:0] r = '0;
    int kd = kind_of(w[6:0]);
    for (int k = 0; k < 32; k++) begin
      case (kd)
        1: r[k] = (k < 12) ? w[20+k] : w[31];
        2: r[k] = (k < 5) ? w[7+k] : (k < 11) ? w[20+k] : w[31];
        3: r[k] = (k == 0) ? 1'b0 : (k < 5) ? w[7+k] : (k < 11) ? w[20+k] :
                  (k == 11) ? w[7] : w[31];
        4: r[k] = (k < 12) ? 1'b0 : w[k];
        5: r[k] = (k == 0) ? 1'b0 : (k < 11) ? w[20+k] : (k == 11) ? w[20] :
                  (k < 20) ? w[k] : w[31];
        default: r[k] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [4:0] ref_shamt(logic [31:0] w);
    if (w[6:0] == 7'b0010011 && (w[14:12] == 3'b001 || w[14:12] == 3'b101)) return w[24:20];
    return 5'd0;
  endfunction

  function automatic logic ref_arith(logic [31:0] w);
    return (w[6:0] == 7'b0010011) && (w[14:12] == 3'b101) && w[30];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: instr %h actual %h expected %h", req, instr, act, exp);
    end
  endtask

  task automatic apply_all(logic [31:0] w);
    @(posedge clk);
    instr = w;
    @(negedge clk);
    check(req_of(w[6:0]), imm, ref_imm(w));
    check("R7", {31'b0, no_imm}, {31'b0, kind_of(w[6:0]) == 0});
    check("R8", {27'b0, shamt}, {27'b0, ref_shamt(w)});
    check("R9", {31'b0, arith}, {31'b0, ref_arith(w)});
    if (kind_of(w[6:0]) != 0) check("R6", {31'b0, imm[31]}, {31'b0, w[31]});
  endtask

  initial begin
    instr = 32'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", imm, 32'h0);
    check("R7", {31'b0, no_imm}, 32'h1);

    // R3: lone bit 7 in a branch lands on immediate bit 11
    apply_all(32'h000000E3);
    check("R3", imm, 32'h00000800);
    // R5: lone sign bit in a jump
    apply_all(32'h8000006F);
    check("R5", imm, 32'hFFF00000);
    // R5: lone bit 20 in a jump lands on immediate bit 11
    apply_all(32'h0010006F);
    check("R5", imm, 32'h00000800);
    // R4: upper with every field bit set
    apply_all(32'hFFFFF037);
    check("R4", imm, 32'hFFFFF000);
    // R9 / R8: arithmetic right shift by 7
    apply_all(32'h40705013);
    check("R8", {27'b0, shamt}, 32'd7);
    check("R9", {31'b0, arith}, 32'd1);
    check("R1", imm, 32'h00000407);
    // R7: register-register word carries no immediate
    apply_all(32'h403100B3);
    check("R7", imm, 32'h0);
    check("R7", {31'b0, no_imm}, 32'h1);
    // R2: store with only low field
    apply_all(32'h00000FA3);
    check("R2", imm, 32'h0000001F);
    // R1: load of -1
    apply_all(32'hFFF00003);
    check("R1", imm, 32'hFFFFFFFF);

    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w = $urandom();
      int sel = $urandom_range(0, 10);
      if (sel < 10) w[6:0] = OPS[sel];
      if ((n % 4) == 0) w[14:12] = (n % 8 == 0) ? 3'b101 : 3'b001;
      apply_all(w);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule